// File: doc/BRIEF.md
# UART Receive Status Flags

This block keeps the error and status flags of an asynchronous serial receiver. A receive shifter, outside this block, sends it one-cycle event pulses: noise seen on a sample, stop bit read as 0, parity mismatch, break character seen, start bit found, false start rejected and frame complete. The block latches these into two readable status bytes. It raises interrupt requests for noise, framing and parity errors, and it gives a strobe that tells the data path to clear the ninth received bit when a break arrives in 9-bit mode.

Software clears a flag in two steps. First it reads the status byte that holds the flag while the flag is set. Then it reads the data register. A new event for that flag between the two reads undoes the first step. A break sets the break flag, the framing-error flag and the receive-full flag. A second break is not accepted until the receive line has gone back to idle-high.

Top module: `uart_rx_errstat`

## Requirements
- R1: After a synchronous active-low reset, both status bytes read 0 and all three interrupt requests are low, whatever the enables are.
- R2: In status byte 1, bit 0 is parity error, bit 1 is framing error, bit 2 is noise and bit 3 is receive-full. In status byte 2, bit 0 is reception-in-progress and bit 1 is break. Every other bit reads 0.
- R3: A noise, stop-bit-zero or parity pulse sets its own flag at the next clock edge. A frame-complete pulse sets receive-full at the next clock edge.
- R4: Each of the noise, framing and parity interrupt outputs is high exactly while its flag is set and its own enable is high. The break flag never raises an interrupt.
- R5: A flag clears at the clock edge of a data-register read only if, in an earlier cycle, the status byte holding it was read while the flag was set. A data read with no such earlier status read leaves the flag set.
- R6: A new set event for a flag, arriving after the status read and before the data read, cancels that flag's pending clear. Other flags that were armed still clear.
- R7: When a set event and a clearing data read land in the same cycle, the flag stays set.
- R8: An accepted break sets the break, framing-error and receive-full flags at the next clock edge.
- R9: The ninth-bit clear strobe is high in the same cycle as an accepted break when 9-bit mode is on. It stays low otherwise.
- R10: The break flag arms only on a status byte 2 read. A status byte 1 read followed by a data read leaves it set.
- R11: After a break is accepted, further break pulses have no effect on any flag or on the strobe. This lasts until the receive line is sampled high at a clock edge.
- R12: Reception-in-progress sets on a start pulse. It clears on frame-complete or false-start. If a start arrives in the same cycle as a clearing pulse, the start wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_noise_i | input | 1 | Noise seen in the current frame (pulse) |
| ev_stop_zero_i | input | 1 | Stop bit sampled as 0 (pulse) |
| ev_parity_i | input | 1 | Parity mismatch (pulse) |
| ev_break_i | input | 1 | Break character detected (pulse) |
| ev_frame_done_i | input | 1 | Frame complete, data available (pulse) |
| ev_start_i | input | 1 | Start bit detected (pulse) |
| ev_false_start_i | input | 1 | Start bit rejected as false (pulse) |
| rx_line_i | input | 1 | Receive line level, 1 = idle |
| rd_stat1_i | input | 1 | Read strobe for status byte 1 |
| rd_stat2_i | input | 1 | Read strobe for status byte 2 |
| rd_data_i | input | 1 | Read strobe for the data register |
| nine_bit_mode_i | input | 1 | 9-bit character mode selected |
| ien_noise_i | input | 1 | Noise interrupt enable |
| ien_frame_i | input | 1 | Framing interrupt enable |
| ien_parity_i | input | 1 | Parity interrupt enable |
| stat1_o | output | STAT_W | Status byte 1 |
| stat2_o | output | STAT_W | Status byte 2 |
| irq_noise_o | output | 1 | Noise interrupt request |
| irq_frame_o | output | 1 | Framing interrupt request |
| irq_parity_o | output | 1 | Parity interrupt request |
| clr_bit9_o | output | 1 | Strobe to clear the received ninth bit |

## Verification
The bench uses the default status width of 8 bits. This lets it check on every step that the upper padding bits of both status bytes stay at 0. With that width, every flag position, every arming path and every priority case (set against clear, start against end, break against re-arm) can be reached through the two status bytes. The break re-arm is tested by holding the line low across a full clear sequence and checking that a second break has no effect.

// File: rtl/uart_rx_errstat_pkg.sv
// Shared bit positions for the receive status bytes.
package uart_rx_errstat_pkg;
    localparam int S1_PAR    = 0;
    localparam int S1_FRM    = 1;
    localparam int S1_NOI    = 2;
    localparam int S1_FULL   = 3;
    localparam int S1_NFLAGS = 4;
    localparam int S2_BUSY   = 0;
    localparam int S2_BRK    = 1;
    localparam int S2_NBITS  = 2;
endpackage

// File: rtl/rxs_flag_cell.sv
// One sticky status flag that clears in two steps.
// A status read while the flag is set arms it. A later data read clears it.
// A set event has priority over everything and drops the arm.
// Assumes read strobes and events are single-cycle pulses.
module rxs_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic rd_stat_i,
    input  logic rd_data_i,
    output logic flag_o
);
    logic flag_q;
    logic armed_q;

    // Set wins, then clear on an armed data read, then arm on a status read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q  <= 1'b0;
            armed_q <= 1'b0;
        end else if (set_i) begin
            flag_q  <= 1'b1;
            armed_q <= 1'b0;
        end else if (rd_data_i && armed_q) begin
            flag_q  <= 1'b0;
            armed_q <= 1'b0;
        end else if (rd_stat_i && flag_q) begin
            armed_q <= 1'b1;
        end
    end

    assign flag_o = flag_q;

    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);

    assert_clear_needs_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(flag_o)) |-> ($past(rd_data_i) && !$past(set_i)));
endmodule

// File: rtl/rxs_break_gate.sv
// Accepts a break pulse only when the line has been idle-high since the
// last accepted break. Ready is 1 out of reset.
module rxs_break_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic brk_ev_i,
    input  logic rx_line_i,
    output logic brk_acc_o
);
    logic ready_q;

    assign brk_acc_o = brk_ev_i && ready_q;

    // Close on acceptance, reopen when the line is sampled high.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ready_q <= 1'b1;
        else if (brk_acc_o)
            ready_q <= 1'b0;
        else if (rx_line_i)
            ready_q <= 1'b1;
    end

    assert_break_once_R11: assert property (@(posedge clk) disable iff (!rst_n)
        brk_acc_o |=> !brk_acc_o);
endmodule

// File: rtl/rxs_busy_track.sv
// Reception-in-progress flag: a start sets it, an end clears it, start wins.
module rxs_busy_track (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic end_i,
    output logic busy_o
);
    logic busy_q;

    // Start has priority over frame end or false start.
    always_ff @(posedge clk) begin
        if (!rst_n)
            busy_q <= 1'b0;
        else if (start_i)
            busy_q <= 1'b1;
        else if (end_i)
            busy_q <= 1'b0;
    end

    assign busy_o = busy_q;

    assert_start_sets_R12: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> busy_o);

    assert_end_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (end_i && !start_i) |=> !busy_o);
endmodule

// File: rtl/uart_rx_errstat.sv
// Receive status flag unit: latches shifter events into two status bytes,
// gates interrupts with their enables and handles break acceptance.
// Assumes all event and read inputs are single-cycle pulses in clk domain.
module uart_rx_errstat
    import uart_rx_errstat_pkg::*;
#(
    parameter int STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_noise_i,
    input  logic              ev_stop_zero_i,
    input  logic              ev_parity_i,
    input  logic              ev_break_i,
    input  logic              ev_frame_done_i,
    input  logic              ev_start_i,
    input  logic              ev_false_start_i,
    input  logic              rx_line_i,
    input  logic              rd_stat1_i,
    input  logic              rd_stat2_i,
    input  logic              rd_data_i,
    input  logic              nine_bit_mode_i,
    input  logic              ien_noise_i,
    input  logic              ien_frame_i,
    input  logic              ien_parity_i,
    output logic [STAT_W-1:0] stat1_o,
    output logic [STAT_W-1:0] stat2_o,
    output logic              irq_noise_o,
    output logic              irq_frame_o,
    output logic              irq_parity_o,
    output logic              clr_bit9_o
);
    localparam int PAD1 = STAT_W - S1_NFLAGS;
    localparam int PAD2 = STAT_W - S2_NBITS;

    logic                  brk_acc;
    logic                  brk_flag;
    logic                  busy;
    logic [S1_NFLAGS-1:0]  set_v;
    logic [S1_NFLAGS-1:0]  flags1;

    rxs_break_gate u_brk (
        .clk       (clk),
        .rst_n     (rst_n),
        .brk_ev_i  (ev_break_i),
        .rx_line_i (rx_line_i),
        .brk_acc_o (brk_acc)
    );

    // Route shifter events (and an accepted break) to the status-1 flags.
    always_comb begin
        set_v          = '0;
        set_v[S1_PAR]  = ev_parity_i;
        set_v[S1_FRM]  = ev_stop_zero_i || brk_acc;
        set_v[S1_NOI]  = ev_noise_i;
        set_v[S1_FULL] = ev_frame_done_i || brk_acc;
    end

    for (genvar g = 0; g < S1_NFLAGS; g++) begin : g_s1
        rxs_flag_cell u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .set_i     (set_v[g]),
            .rd_stat_i (rd_stat1_i),
            .rd_data_i (rd_data_i),
            .flag_o    (flags1[g])
        );
    end

    rxs_flag_cell u_brk_cell (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (brk_acc),
        .rd_stat_i (rd_stat2_i),
        .rd_data_i (rd_data_i),
        .flag_o    (brk_flag)
    );

    rxs_busy_track u_busy (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (ev_start_i),
        .end_i   (ev_frame_done_i || ev_false_start_i),
        .busy_o  (busy)
    );

    assign stat1_o = {{PAD1{1'b0}}, flags1};
    assign stat2_o = {{PAD2{1'b0}}, brk_flag, busy};

    assign irq_noise_o  = flags1[S1_NOI] && ien_noise_i;
    assign irq_frame_o  = flags1[S1_FRM] && ien_frame_i;
    assign irq_parity_o = flags1[S1_PAR] && ien_parity_i;
    assign clr_bit9_o   = brk_acc && nine_bit_mode_i;

    assert_break_side_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat2_o[S2_BRK]) |-> (stat1_o[S1_FRM] && stat1_o[S1_FULL]));
endmodule

// File: tb/uart_rx_errstat_tb.sv
module uart_rx_errstat_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    // Drive word bits
    localparam logic [14:0] NOI = 15'h0001, SZ  = 15'h0002, PAR = 15'h0004;
    localparam logic [14:0] BRK = 15'h0008, DN  = 15'h0010, ST  = 15'h0020;
    localparam logic [14:0] FS  = 15'h0040, L   = 15'h0080, RD1 = 15'h0100;
    localparam logic [14:0] RD2 = 15'h0200, RDD = 15'h0400, NIN = 15'h0800;
    localparam logic [14:0] IN_ = 15'h1000, IF_ = 15'h2000, IP_ = 15'h4000;
    // Expected word bits
    localparam logic [9:0] E_P  = 10'h001, E_F  = 10'h002, E_N  = 10'h004;
    localparam logic [9:0] E_RF = 10'h008, E_BS = 10'h010, E_BK = 10'h020;
    localparam logic [9:0] E_IP = 10'h040, E_IF = 10'h080, E_IN = 10'h100;
    localparam logic [9:0] E_C9 = 10'h200, E_0  = 10'h000;

    typedef struct packed {
        logic [3:0]  req;
        logic [9:0]  exp;
        logic [14:0] drv;
    } vec_t;

    localparam int NV = 35;
    localparam vec_t VECS [NV] = '{
        '{4'd3,  E_N,              NOI | L},          // R3 noise sets
        '{4'd4,  E_N | E_IN,       L | IN_},          // R4 enabled irq
        '{4'd5,  E_N,              L | RD2},          // R5 wrong status byte
        '{4'd5,  E_N,              L | RDD},          // R5 data read unarmed
        '{4'd5,  E_N,              L | RD1},          // R5 arm
        '{4'd5,  E_0,              L | RDD},          // R5 clear
        '{4'd3,  E_F | E_P,        SZ | PAR | L},     // R3 framing, parity
        '{4'd4,  E_F | E_P | E_IF, L | IF_},          // R4
        '{4'd4,  E_F | E_P | E_IP, L | IP_},          // R4
        '{4'd6,  E_F | E_P,        L | RD1},          // R6 arm both
        '{4'd6,  E_F | E_P,        PAR | L},          // R6 parity re-sets
        '{4'd6,  E_P,              L | RDD},          // R6 only framing clears
        '{4'd7,  E_P,              L | RD1},          // R7 arm
        '{4'd7,  E_P,              PAR | RDD | L},    // R7 set beats clear
        '{4'd7,  E_P,              L | RDD},          // R7 arm was dropped
        '{4'd5,  E_P,              L | RD1},          // R5
        '{4'd5,  E_0,              L | RDD},          // R5
        '{4'd12, E_BS,             ST | L},           // R12 start
        '{4'd12, E_BS,             L},                // R12 holds
        '{4'd12, E_RF,             DN | L},           // R12 done, R3 full
        '{4'd12, E_RF | E_BS,      ST | L},           // R12
        '{4'd12, E_RF,             FS | L},           // R12 false start
        '{4'd12, E_RF | E_BS,      ST | DN | L},      // R12 start wins
        '{4'd12, E_RF,             DN | L},           // R12
        '{4'd5,  E_RF,             L | RD1},          // R5
        '{4'd5,  E_0,              L | RDD},          // R5
        '{4'd8,  E_C9 | E_F | E_RF | E_BK, BRK | NIN}, // R8 R9 break
        '{4'd10, E_F | E_RF | E_BK, RD1},             // R10
        '{4'd10, E_BK,             RDD},              // R10 break stays
        '{4'd10, E_BK,             RD2},              // R10 arm break
        '{4'd10, E_0,              RDD},              // R10 clear
        '{4'd11, E_0,              BRK | NIN},        // R11 ignored
        '{4'd11, E_0,              L},                // R11 line idle
        '{4'd9,  E_F | E_RF | E_BK, BRK},             // R9 no strobe, R8
        '{4'd4,  E_F | E_RF | E_BK | E_IF, IN_ | IF_ | IP_} // R4 break no irq
    };

    logic [14:0] drv = L;
    logic [STW-1:0] stat1, stat2;
    localparam int STW = 8;
    logic irq_n, irq_f, irq_p, clr9;

    uart_rx_errstat #(.STAT_W(STW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .ev_noise_i(drv[0]), .ev_stop_zero_i(drv[1]), .ev_parity_i(drv[2]),
        .ev_break_i(drv[3]), .ev_frame_done_i(drv[4]), .ev_start_i(drv[5]),
        .ev_false_start_i(drv[6]), .rx_line_i(drv[7]),
        .rd_stat1_i(drv[8]), .rd_stat2_i(drv[9]), .rd_data_i(drv[10]),
        .nine_bit_mode_i(drv[11]),
        .ien_noise_i(drv[12]), .ien_frame_i(drv[13]), .ien_parity_i(drv[14]),
        .stat1_o(stat1), .stat2_o(stat2),
        .irq_noise_o(irq_n), .irq_frame_o(irq_f), .irq_parity_o(irq_p),
        .clr_bit9_o(clr9)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d actual %h expected %h", req, act, exp);
        end
    endtask

    // Check outputs after an edge: status bytes and interrupts.
    task automatic chk_regs(input int req, input logic [9:0] e);
        chk(req, {stat2, stat1, 5'b0, irq_n, irq_f, irq_p},
            {{(STW-2){1'b0}}, e[5:4], {(STW-4){1'b0}}, e[3:0], 5'b0, e[8], e[7], e[6]});
    endtask

    initial begin
        #(20 * 5000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state with all enables high
        drv = L | IN_ | IF_ | IP_;
        repeat (3) @(posedge clk);
        #2;
        chk_regs(1, E_0);                       // R1 R2
        @(negedge clk);
        rst_n = 1'b1;
        drv = L;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drv = VECS[i].drv;
            #5;
            chk(int'(VECS[i].req), {31'b0, clr9}, {31'b0, VECS[i].exp[9]}); // R9
            @(posedge clk);
            #2;
            chk_regs(int'(VECS[i].req), VECS[i].exp);                         // R2
        end

        // R1: reset while flags are set clears them
        @(negedge clk);
        drv = L | IN_ | IF_ | IP_;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #2;
        chk_regs(1, E_0);                       // R1
        @(negedge clk);
        rst_n = 1'b1;

        // R11: after reset a break is accepted at once
        drv = BRK | NIN;
        #5;
        chk(11, {31'b0, clr9}, 32'd1);          // R11 R9
        @(posedge clk);
        #2;
        chk_regs(8, E_F | E_RF | E_BK);         // R8
        @(negedge clk);
        drv = L;

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule